// File: doc/BRIEF.md
# Up-Counting Timer with One Capture/Compare Channel

This block is a 16-bit up-counting timer fed by an 8-bit clock divider. The counter climbs by one on each divider tick and wraps to zero after it reaches the reload limit. Each wrap raises a one-cycle update pulse. A software update strobe also raises that pulse, and it clears both the counter and the divider. The divide ratio always goes through a shadow copy that is loaded only at update pulses. The reload limit can either take effect as soon as it is written or wait in a shadow copy for the next update pulse.

A single channel sits beside the counter and has two modes. In waveform mode it drives a registered PWM output that is active while the counter is below the compare value. In capture mode it watches a trigger pin and, on the selected edge, copies the counter into the compare register and sets a sticky flag. One polarity bit does double duty. In waveform mode it selects the active output level. In capture mode it selects the trigger edge.

Software programs the block through a flat register port. Writes take effect on a clock edge. Reads are combinational from the read address.

Top module: `gp_timer`

Register addresses (3-bit): 0 divider value (bits 7:0), 1 reload limit (bits 15:0), 2 compare/capture value, 3 channel control, 4 live counter (read only). Unused addresses read as zero. Control bits: 0 channel enable, 1 polarity, 2 mode (0 PWM, 1 capture), 3 compare preload enable, 4 reload preload enable, 5 capture flag. Reading bit 5 returns the flag. Writing 1 to bit 5 clears the flag.

## Requirements
- R1: The counter advances once every (D+1) clock cycles, where D is the active 8-bit divider value.
- R2: A written divider value becomes active only at an update pulse. The software update strobe is an update pulse, and it also clears the counter and the divider phase, so the counter reads N/(D+1) (rounded down) N cycles after the strobe.
- R3: When the counter is at or above the active reload limit on a tick, it wraps to 0 and `update_evt` is high for one cycle. The reload limit resets to 0xFFFF.
- R4: With reload preload clear (control bit 4 = 0), a written reload limit applies at once. With it set, the new limit applies only from the next update pulse.
- R5: In PWM mode (control bit 2 = 0) with the channel enabled, `pwm_out` is active while counter < compare value. Over one period of (L+1)(D+1) cycles it is active for min(C, L+1)(D+1) cycles. Polarity 0 means active high and polarity 1 means active low.
- R6: With compare preload set (control bit 3 = 1), a written compare value drives PWM only from the next update pulse. With it clear, the value applies at once.
- R7: In capture mode (control bit 2 = 1), polarity 0 captures on a rising trigger edge and polarity 1 captures on a falling edge. The opposite edge does nothing. The trigger passes through two sync flops, so a transition driven just after counter value m is latched as m+2 (divider 0).
- R8: A capture sets `cap_flag`, and the flag stays set until software writes 1 to control bit 5.
- R9: With the channel disabled (control bit 0 = 0), `pwm_out` sits at its inactive level (equal to the polarity bit) and trigger edges neither capture nor set the flag.
- R10: After reset the divider, compare and control registers read 0, the reload limit reads 0xFFFF, and `pwm_out` and `cap_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| sw_update | input | 1 | Software update request |
| trig_in | input | 1 | Asynchronous capture trigger |
| pwm_out | output | 1 | Channel waveform output |
| update_evt | output | 1 | One-cycle update pulse |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The hardest cases to reach from the ports are the deferred loads, because in those cases a shadow copy quietly differs from the value software just wrote. The stimulus sets up that window on purpose. It issues a software update to load the shadows, writes a new value straight afterwards, and then observes the counter, the update-pulse count or the PWM level at a known cycle before the next wrap. It repeats the observation after another update to show that the new value has landed. Capture latency is pinned down by driving the trigger a fixed number of cycles after an update strobe and checking the exact latched count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    ADR_DIV    = 3'd0,
    ADR_RELOAD = 3'd1,
    ADR_CMP    = 3'd2,
    ADR_CTL    = 3'd3,
    ADR_COUNT  = 3'd4
  } tmr_addr_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_POL  = 1;
  localparam int CTL_MODE = 2;
  localparam int CTL_CPE  = 3;
  localparam int CTL_RPE  = 4;
  localparam int CTL_FLAG = 5;
  localparam int CTL_W    = 5;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_wr,
  input  logic             upd,
  input  logic             sw_upd,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q, phase_d;
  logic [DIV_W-1:0] div_act_q, div_act_d;

  assign tick = (phase_q == div_act_q);

  always_comb begin
    div_act_d = div_act_q;
    if (upd) div_act_d = div_wr;
    if (sw_upd || tick) phase_d = '0;
    else                phase_d = phase_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= '0;
      div_act_q <= '0;
    end else begin
      phase_q   <= phase_d;
      div_act_q <= div_act_d;
    end
  end

  a_r2_div_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(div_act_q));
  a_r1_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_upd && !tick) |=> (phase_q == $past(phase_q) + DIV_W'(1)));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sw_upd,
  input  logic             rpe,
  input  logic [CNT_W-1:0] lim_wr,
  output logic [CNT_W-1:0] cnt,
  output logic             upd
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_shd_q, lim_shd_d;
  logic [CNT_W-1:0] lim_eff;
  logic             wrap;

  assign lim_eff = rpe ? lim_shd_q : lim_wr;
  assign wrap    = tick && (cnt_q >= lim_eff);
  assign upd     = sw_upd || wrap;
  assign cnt     = cnt_q;

  always_comb begin
    cnt_d     = cnt_q;
    lim_shd_d = lim_shd_q;
    if (upd)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + CNT_W'(1);
    if (!rpe || upd) lim_shd_d = lim_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lim_shd_q <= '1;
    end else begin
      cnt_q     <= cnt_d;
      lim_shd_q <= lim_shd_d;
    end
  end

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cnt_q == '0));
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !upd) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sw_upd) |=> $stable(cnt_q));
  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rpe && !upd) |=> $stable(lim_shd_q));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             upd,
  input  logic             ch_en,
  input  logic             pol,
  input  logic             cap_mode,
  input  logic             cpe,
  input  logic             trig_in,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cmp_val,
  output logic             pwm_out,
  output logic             cap_flag
);
  logic             sync1_q, sync2_q, trig_dly_q;
  logic             rise, fall, cap_hit;
  logic [CNT_W-1:0] cmp_q, cmp_d, cmp_shd_q, cmp_shd_d, cmp_eff;
  logic             pwm_q, pwm_d, flag_q, flag_d;

  assign rise    = sync2_q && !trig_dly_q;
  assign fall    = !sync2_q && trig_dly_q;
  assign cap_hit = ch_en && cap_mode && (pol ? fall : rise);
  assign cmp_eff = cpe ? cmp_shd_q : cmp_q;

  always_comb begin
    cmp_d     = cmp_q;
    cmp_shd_d = cmp_shd_q;
    flag_d    = flag_q;
    if (cap_hit)     cmp_d = cnt;
    else if (cmp_wr) cmp_d = cmp_wdata;
    if (!cpe || upd) cmp_shd_d = cmp_q;
    if (cap_hit)       flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    if (ch_en && !cap_mode && (cnt < cmp_eff)) pwm_d = !pol;
    else                                       pwm_d = pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q    <= 1'b0;
      sync2_q    <= 1'b0;
      trig_dly_q <= 1'b0;
      cmp_q      <= '0;
      cmp_shd_q  <= '0;
      pwm_q      <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      sync1_q    <= trig_in;
      sync2_q    <= sync1_q;
      trig_dly_q <= sync2_q;
      cmp_q      <= cmp_d;
      cmp_shd_q  <= cmp_shd_d;
      pwm_q      <= pwm_d;
      flag_q     <= flag_d;
    end
  end

  assign cmp_val  = cmp_q;
  assign pwm_out  = pwm_q;
  assign cap_flag = flag_q;

  a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> (pwm_out == $past(pol)));
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> cap_flag);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);
  a_r7_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (cmp_val == $past(cnt)));
  a_r9_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en && !cmp_wr) |=> $stable(cmp_val));
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             sw_update,
  input  logic             trig_in,
  output logic             pwm_out,
  output logic             update_evt,
  output logic             cap_flag
);
  logic             rst_s1_q, rst_sync_n;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             tick, upd, flag_clr, cmp_wr;
  logic [CNT_W-1:0] cnt, cmp_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  assign cmp_wr   = wr_en && (wr_addr == ADR_CMP);
  assign flag_clr = wr_en && (wr_addr == ADR_CTL) && wr_data[CTL_FLAG];

  always_comb begin
    div_d = div_q;
    lim_d = lim_q;
    ctl_d = ctl_q;
    if (wr_en) begin
      case (wr_addr)
        ADR_DIV:    div_d = wr_data[DIV_W-1:0];
        ADR_RELOAD: lim_d = wr_data;
        ADR_CTL:    ctl_d = wr_data[CTL_W-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      div_q <= '0;
      lim_q <= '1;
      ctl_q <= '0;
    end else begin
      div_q <= div_d;
      lim_q <= lim_d;
      ctl_q <= ctl_d;
    end
  end

  tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .div_wr(div_q), .upd(upd),
    .sw_upd(sw_update), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .sw_upd(sw_update),
    .rpe(ctl_q[CTL_RPE]), .lim_wr(lim_q), .cnt(cnt), .upd(upd)
  );

  tmr_channel #(.CNT_W(CNT_W)) u_ch (
    .clk(clk), .rst_n(rst_sync_n), .cnt(cnt), .upd(upd),
    .ch_en(ctl_q[CTL_EN]), .pol(ctl_q[CTL_POL]), .cap_mode(ctl_q[CTL_MODE]),
    .cpe(ctl_q[CTL_CPE]), .trig_in(trig_in), .cmp_wr(cmp_wr),
    .cmp_wdata(wr_data), .flag_clr(flag_clr), .cmp_val(cmp_val),
    .pwm_out(pwm_out), .cap_flag(cap_flag)
  );

  assign update_evt = upd;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_DIV:    rd_data[DIV_W-1:0] = div_q;
      ADR_RELOAD: rd_data = lim_q;
      ADR_CMP:    rd_data = cmp_val;
      ADR_CTL: begin
        rd_data[CTL_W-1:0] = ctl_q;
        rd_data[CTL_FLAG]  = cap_flag;
      end
      ADR_COUNT:  rd_data = cnt;
      default:    ;
    endcase
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (update_evt && !sw_update) |=> !update_evt);
  a_r2_sw_update_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sw_update |=> (cnt == '0));
endmodule

// File: tb/tb_gp_timer.sv
module tb_gp_timer;
  logic        clk, rst_n, wr_en, sw_update, trig_in;
  logic [2:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        pwm_out, update_evt, cap_flag;
  int checks = 0;
  int errors = 0;

  gp_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sw_update(sw_update), .trig_in(trig_in), .pwm_out(pwm_out),
    .update_evt(update_evt), .cap_flag(cap_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic upd_sw();
    sw_update = 1'b1;
    @(negedge clk);
    sw_update = 1'b0;
  endtask

  task automatic count_upd(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (update_evt) c++;
    end
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) c++;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd0, v); check(v == 16'h0, "R10 divider", v, 0);
    rd(3'd1, v); check(v == 16'hFFFF, "R10 reload", v, 16'hFFFF);
    rd(3'd2, v); check(v == 16'h0, "R10 compare", v, 0);
    rd(3'd3, v); check(v == 16'h0, "R10 control", v, 0);
    check(pwm_out == 1'b0, "R10 pwm", pwm_out, 0);
    check(cap_flag == 1'b0, "R10 flag", cap_flag, 0);
  endtask

  task automatic t_divider();
    logic [15:0] v;
    upd_sw();
    wr(3'd0, 16'd3);
    repeat (19) @(negedge clk);
    rd(3'd4, v); check(v == 16'd20, "R2 divider deferred", v, 20);
    upd_sw();
    repeat (20) @(negedge clk);
    rd(3'd4, v); check(v == 16'd5, "R1 divide by 4", v, 5);
  endtask

  task automatic t_reload();
    int c;
    wr(3'd0, 16'd0);
    wr(3'd3, 16'h0010);
    wr(3'd1, 16'hFFFF);
    upd_sw();
    wr(3'd1, 16'd5);
    count_upd(60, c); check(c == 0, "R4 reload preloaded waits", c, 0);
    upd_sw();
    count_upd(60, c); check(c == 10, "R3 wrap period 6 after update", c, 10);
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'd11);
    count_upd(120, c); check(c == 10, "R4 reload immediate", c, 10);
  endtask

  task automatic t_pwm();
    int c;
    logic [15:0] v;
    wr(3'd0, 16'd1);
    wr(3'd1, 16'd9);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'h0001);
    upd_sw();
    repeat (20) @(negedge clk);
    count_high(20, c); check(c == 8, "R5 duty high", c, 8);
    wr(3'd3, 16'h0003);
    repeat (20) @(negedge clk);
    count_high(20, c); check(c == 12, "R5 active low", c, 12);
    wr(3'd3, 16'h0001);
    wr(3'd2, 16'd12);
    repeat (20) @(negedge clk);
    count_high(20, c); check(c == 20, "R5 compare above limit", c, 20);
    wr(3'd2, 16'd0);
    repeat (20) @(negedge clk);
    count_high(20, c); check(c == 0, "R5 compare zero", c, 0);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'h0000);
    count_high(40, c); check(c == 0, "R9 disabled pol0", c, 0);
    wr(3'd3, 16'h0002);
    count_high(40, c); check(c == 40, "R9 disabled pol1", c, 40);
    // R6: preload on, compare 4 latched by update, then 8 written
    wr(3'd0, 16'd0);
    wr(3'd1, 16'hFFFF);
    wr(3'd3, 16'h0009);
    upd_sw();
    wr(3'd2, 16'd8);
    repeat (6) @(negedge clk);
    check(pwm_out == 1'b0, "R6 compare preload deferred", pwm_out, 0);
    wr(3'd3, 16'h0001);
    upd_sw();
    wr(3'd2, 16'd8);
    repeat (6) @(negedge clk);
    check(pwm_out == 1'b1, "R6 compare immediate", pwm_out, 1);
    rd(3'd2, v); check(v == 16'd8, "R6 compare readback", v, 8);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    trig_in = 1'b0;
    wr(3'd0, 16'd0);
    wr(3'd1, 16'hFFFF);
    wr(3'd3, 16'h0005);
    repeat (4) @(negedge clk);
    upd_sw();
    repeat (10) @(negedge clk);
    trig_in = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd2, v); check(v == 16'd12, "R7 rising capture value", v, 12);
    check(cap_flag == 1'b1, "R8 flag set", cap_flag, 1);
    repeat (10) @(negedge clk);
    check(cap_flag == 1'b1, "R8 flag sticky", cap_flag, 1);
    wr(3'd3, 16'h0025);
    check(cap_flag == 1'b0, "R8 flag cleared", cap_flag, 0);
    // R9: disabled channel ignores edges
    wr(3'd2, 16'h1234);
    wr(3'd3, 16'h0006);
    trig_in = 1'b0; repeat (5) @(negedge clk);
    trig_in = 1'b1; repeat (5) @(negedge clk);
    rd(3'd2, v); check(v == 16'h1234, "R9 no capture when disabled", v, 16'h1234);
    check(cap_flag == 1'b0, "R9 no flag when disabled", cap_flag, 0);
    // R7: falling edge selected, rising ignored
    trig_in = 1'b0; repeat (5) @(negedge clk);
    wr(3'd3, 16'h0007);
    trig_in = 1'b1; repeat (5) @(negedge clk);
    check(cap_flag == 1'b0, "R7 rising ignored with pol1", cap_flag, 0);
    upd_sw();
    repeat (20) @(negedge clk);
    trig_in = 1'b0;
    repeat (5) @(negedge clk);
    rd(3'd2, v); check(v == 16'd22, "R7 falling capture value", v, 22);
    check(cap_flag == 1'b1, "R8 flag on falling", cap_flag, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; sw_update = 1'b0; trig_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_divider();
    t_reload();
    t_pwm();
    t_capture();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule